// File: doc/BRIEF.md
# Programmable Dual-Layout Frequency Generator Bank

This block holds six programmable frequency generators that share one system clock. Each generator takes one of three source tick streams. The streams are single-cycle clock-enable strobes that stand for a CPU-clock source and two auxiliary PLL sources. The generator divides the chosen stream by a programmed value and drives a registered divided-clock level. Software sets the generators through two 32-bit control registers on a simple write port and a combinational read port. Each control register carries three 10-bit generator fields and one shared scale bit.

A parameter chooses between two field layouts. In the legacy layout each field has a one-bit source select and its own enable bit, and the divisor is always even. The extended layout replaces both with a two-bit selector whose zero code means "off". Its scale bit switches the divide law between 2·(N+1) and N+1. In the extended layout the block remembers the last non-zero selector of each generator. Two command addresses let software switch generators off and back on, or preset a source while a generator is off, without losing that choice. Settings that arrive while a generator runs wait for the end of the current output period, so no shortened pulse appears. Switching a generator off takes effect at once.

Top module: `freq_gen_bank`

## Requirements
- R1: Generator i lives in the 10-bit field at bit 10·(i mod 3) of control register i/3, which sits at address 0 or 1. A read of either address returns the stored 32-bit value.
- R2: Legacy layout: field bit 1 enables the generator. Field bit 0 selects the source (0 = CPU tick, 1 = auxiliary tick 1). Field bits 9:2 hold N. The divisor is 2·(N+1), and bit 30 has no effect.
- R3: Extended layout: field bits 1:0 are a selector. Code 0 means off, 1 selects auxiliary tick 2, 2 selects the CPU tick and 3 selects auxiliary tick 1. The generator counts as enabled exactly when its selector is non-zero.
- R4: Extended layout: bit 30 of a register is the scale bit for its three generators. When it is set the divisor is N+1; when it is clear the divisor is 2·(N+1).
- R5: In each output period of D source ticks, the output is low for ceil(D/2) ticks and then high for floor(D/2) ticks. The internal tick count never exceeds D−1.
- R6: With a divisor of 1, the output is a copy of the selected source strobe, delayed by one cycle.
- R7: A change of divider, scale or source for a running generator takes effect only at the end of its current output period.
- R8: A disabled generator drives its output low from the next cycle on and clears its counter. Enabling it starts a new period at count 0, beginning with the low phase.
- R9: A read of address 2 returns one enable bit per generator in bits 5:0.
- R10: Extended layout: a write to address 2 restores the remembered selector of generator i when bit i is set, and writes selector 0 when bit 8+i is set. When both bits are set, the off command wins.
- R11: Extended layout: a write to address 3 with bit 16+i set stores the non-zero code in bits 2i+1:2i as the remembered source of generator i. The code is copied into the live selector only if the generator is currently enabled. A zero code is ignored. A read of address 3 returns the remembered codes packed 2 bits per generator.
- R12: Reset clears both control registers and drives all outputs low. It sets every remembered code to 1. Writing a non-zero selector directly into a control register also updates that generator's remembered code.
- R13: Legacy layout: writes to addresses 2 and 3 have no effect, and a read of address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write address (0–1 control, 2 command, 3 preset) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Read data, combinational |
| src_tick | input | 3 | Source strobes: bit 0 CPU, bit 1 aux 1, bit 2 aux 2 |
| gen_out | output | 6 | Divided clock outputs, one per generator |

## Verification
Several properties are checked on every cycle. A generator whose decoded enable is low must show a low output on the next cycle. No counter may pass its period limit. The active limit may change only on a cycle where the counter has returned to zero, which means at a period boundary or while the generator is off. No remembered source code may ever be zero. Only the bench scenarios can show the rest, because that needs measured waveforms and readback. This covers the period and high-time for each source, scale and layout, and the mixed period that spans a divider change. It also covers the enable, disable and preset command sequences, with disable winning over enable, and the legacy layout ignoring commands.

// File: rtl/fg_pkg.sv
package fg_pkg;
  localparam int REG_W      = 32;
  localparam int FIELD_W    = 10;
  localparam int DIV_W      = 8;
  localparam int CNT_W      = DIV_W + 1;
  localparam int SCALE_POS  = 30;
  localparam int SRC_N      = 3;
  localparam int EN_BASE    = 0;
  localparam int DIS_BASE   = 8;
  localparam int PMASK_BASE = 16;

  // tick vector indices
  localparam logic [1:0] TICK_CPU  = 2'd0;
  localparam logic [1:0] TICK_AUX1 = 2'd1;
  localparam logic [1:0] TICK_AUX2 = 2'd2;

  typedef enum logic [1:0] {
    SEL_OFF  = 2'd0,
    SEL_AUX2 = 2'd1,
    SEL_CPU  = 2'd2,
    SEL_AUX1 = 2'd3
  } ext_sel_e;

  typedef struct packed {
    logic             en;
    logic [1:0]       src;   // index into tick vector
    logic [CNT_W-1:0] lim;   // divisor minus one
  } gen_cfg_t;

  function automatic gen_cfg_t decode_field(input bit legacy,
                                            input logic [FIELD_W-1:0] fld,
                                            input logic scale);
    gen_cfg_t c;
    logic [DIV_W-1:0] n;
    n = fld[FIELD_W-1:2];
    if (legacy) begin
      c.en  = fld[1];
      c.src = fld[0] ? TICK_AUX1 : TICK_CPU;
      c.lim = {n, 1'b1};
    end else begin
      c.en = (fld[1:0] != SEL_OFF);
      case (fld[1:0])
        SEL_AUX2: c.src = TICK_AUX2;
        SEL_CPU:  c.src = TICK_CPU;
        default:  c.src = TICK_AUX1;
      endcase
      c.lim = scale ? {1'b0, n} : {n, 1'b1};
    end
    return c;
  endfunction
endpackage

// File: rtl/fg_regs.sv
module fg_regs
  import fg_pkg::*;
#(
  parameter bit LEGACY      = 1'b0,
  parameter int NUM_REGS    = 2,
  parameter int GEN_PER_REG = 3
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [$clog2(NUM_REGS+2)-1:0]     wr_addr,
  input  logic [REG_W-1:0]                  wr_data,
  input  logic [$clog2(NUM_REGS+2)-1:0]     rd_addr,
  output logic [REG_W-1:0]                  rd_data,
  output gen_cfg_t [NUM_REGS*GEN_PER_REG-1:0] cfg_o,
  output logic [2*NUM_REGS*GEN_PER_REG-1:0] mem_codes_o
);
  localparam int NUM_GEN     = NUM_REGS * GEN_PER_REG;
  localparam int ADDR_W      = $clog2(NUM_REGS + 2);
  localparam int CMD_ADDR    = NUM_REGS;
  localparam int PRESET_ADDR = NUM_REGS + 1;

  logic [REG_W-1:0] ctrl_q [NUM_REGS];
  logic [REG_W-1:0] ctrl_n [NUM_REGS];
  logic [1:0]       mem_q  [NUM_GEN];
  logic [1:0]       mem_n  [NUM_GEN];

  // next-state
  always_comb begin
    for (int r = 0; r < NUM_REGS; r++) ctrl_n[r] = ctrl_q[r];
    for (int i = 0; i < NUM_GEN; i++)  mem_n[i]  = mem_q[i];
    if (wr_en) begin
      for (int r = 0; r < NUM_REGS; r++) begin
        if (wr_addr == ADDR_W'(r)) begin
          ctrl_n[r] = wr_data;
          if (!LEGACY) begin
            for (int k = 0; k < GEN_PER_REG; k++) begin
              if (wr_data[k*FIELD_W +: 2] != SEL_OFF)
                mem_n[r*GEN_PER_REG+k] = wr_data[k*FIELD_W +: 2];
            end
          end
        end
      end
      if (!LEGACY && wr_addr == ADDR_W'(CMD_ADDR)) begin
        for (int i = 0; i < NUM_GEN; i++) begin
          if (wr_data[EN_BASE+i])
            ctrl_n[i/GEN_PER_REG][(i%GEN_PER_REG)*FIELD_W +: 2] = mem_q[i];
          if (wr_data[DIS_BASE+i])
            ctrl_n[i/GEN_PER_REG][(i%GEN_PER_REG)*FIELD_W +: 2] = SEL_OFF;
        end
      end
      if (!LEGACY && wr_addr == ADDR_W'(PRESET_ADDR)) begin
        for (int i = 0; i < NUM_GEN; i++) begin
          if (wr_data[PMASK_BASE+i] && wr_data[2*i +: 2] != SEL_OFF) begin
            mem_n[i] = wr_data[2*i +: 2];
            if (ctrl_q[i/GEN_PER_REG][(i%GEN_PER_REG)*FIELD_W +: 2] != SEL_OFF)
              ctrl_n[i/GEN_PER_REG][(i%GEN_PER_REG)*FIELD_W +: 2] = wr_data[2*i +: 2];
          end
        end
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_REGS; r++) ctrl_q[r] <= '0;
      for (int i = 0; i < NUM_GEN; i++)  mem_q[i]  <= SEL_AUX2;
    end else begin
      for (int r = 0; r < NUM_REGS; r++) ctrl_q[r] <= ctrl_n[r];
      for (int i = 0; i < NUM_GEN; i++)  mem_q[i]  <= mem_n[i];
    end
  end

  // field decode
  generate
    for (genvar g = 0; g < NUM_GEN; g++) begin : g_dec
      assign cfg_o[g] = decode_field(LEGACY,
                          ctrl_q[g/GEN_PER_REG][(g%GEN_PER_REG)*FIELD_W +: FIELD_W],
                          ctrl_q[g/GEN_PER_REG][SCALE_POS]);
      assign mem_codes_o[2*g +: 2] = mem_q[g];
    end
  endgenerate

  // read mux
  always_comb begin
    rd_data = '0;
    for (int r = 0; r < NUM_REGS; r++)
      if (rd_addr == ADDR_W'(r)) rd_data = ctrl_q[r];
    if (rd_addr == ADDR_W'(CMD_ADDR))
      for (int i = 0; i < NUM_GEN; i++) rd_data[i] = cfg_o[i].en;
    if (!LEGACY && rd_addr == ADDR_W'(PRESET_ADDR))
      rd_data[2*NUM_GEN-1:0] = mem_codes_o;
  end
endmodule

// File: rtl/fg_cell.sv
module fg_cell
  import fg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] tick_i,
  input  gen_cfg_t         cfg_i,
  output logic             gen_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] lim_o
);
  gen_cfg_t         act_q, act_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             out_q, out_n;
  logic             tick_cur, tick_nxt;
  logic [CNT_W:0]   div_n, low_n;

  function automatic logic pick(input logic [SRC_N-1:0] t, input logic [1:0] s);
    case (s)
      TICK_CPU:  return t[0];
      TICK_AUX1: return t[1];
      TICK_AUX2: return t[2];
      default:   return 1'b0;
    endcase
  endfunction

  always_comb begin
    act_n    = act_q;
    cnt_n    = cnt_q;
    tick_cur = pick(tick_i, act_q.src);
    if (!cfg_i.en || !act_q.en) begin
      // off, or being switched off: settle immediately
      act_n = cfg_i;
      cnt_n = '0;
    end else if (tick_cur) begin
      if (cnt_q == act_q.lim) begin
        cnt_n = '0;
        act_n = cfg_i;   // period boundary: take new settings
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
    tick_nxt = pick(tick_i, act_n.src);
    div_n    = {1'b0, act_n.lim} + 1'b1;
    low_n    = div_n - (div_n >> 1);
    if (!act_n.en)
      out_n = 1'b0;
    else if (act_n.lim == '0)
      out_n = tick_nxt;
    else
      out_n = ({1'b0, cnt_n} >= low_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      act_q <= act_n;
      cnt_q <= cnt_n;
      out_q <= out_n;
    end
  end

  assign gen_o = out_q;
  assign cnt_o = cnt_q;
  assign lim_o = act_q.lim;
endmodule

// File: rtl/freq_gen_bank.sv
module freq_gen_bank
  import fg_pkg::*;
#(
  parameter bit LEGACY_LAYOUT = 1'b0,
  parameter int NUM_REGS      = 2,
  parameter int GEN_PER_REG   = 3
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_en,
  input  logic [$clog2(NUM_REGS+2)-1:0]        wr_addr,
  input  logic [31:0]                          wr_data,
  input  logic [$clog2(NUM_REGS+2)-1:0]        rd_addr,
  output logic [31:0]                          rd_data,
  input  logic [2:0]                           src_tick,
  output logic [NUM_REGS*GEN_PER_REG-1:0]      gen_out
);
  localparam int NUM_GEN = NUM_REGS * GEN_PER_REG;

  gen_cfg_t [NUM_GEN-1:0]   cfg;
  logic [NUM_GEN-1:0]       cfg_en;
  logic [NUM_GEN*CNT_W-1:0] cnt_all;
  logic [NUM_GEN*CNT_W-1:0] lim_all;
  logic [2*NUM_GEN-1:0]     mem_codes;

  fg_regs #(
    .LEGACY(LEGACY_LAYOUT), .NUM_REGS(NUM_REGS), .GEN_PER_REG(GEN_PER_REG)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .cfg_o(cfg), .mem_codes_o(mem_codes)
  );

  generate
    for (genvar g = 0; g < NUM_GEN; g++) begin : g_cell
      assign cfg_en[g] = cfg[g].en;
      fg_cell u_cell (
        .clk(clk), .rst_n(rst_n),
        .tick_i(src_tick), .cfg_i(cfg[g]),
        .gen_o(gen_out[g]),
        .cnt_o(cnt_all[g*CNT_W +: CNT_W]),
        .lim_o(lim_all[g*CNT_W +: CNT_W])
      );
    end
  endgenerate
endmodule

// File: rtl/fg_checker.sv
module fg_checker
  import fg_pkg::*;
#(
  parameter int NUM_GEN = 6
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NUM_GEN-1:0]       cfg_en,
  input logic [NUM_GEN-1:0]       gen_out,
  input logic [NUM_GEN*CNT_W-1:0] cnt_all,
  input logic [NUM_GEN*CNT_W-1:0] lim_all,
  input logic [2*NUM_GEN-1:0]     mem_codes
);
  generate
    for (genvar g = 0; g < NUM_GEN; g++) begin : g_chk
      assert_out_low_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en[g] |=> !gen_out[g]);
      assert_cnt_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_all[g*CNT_W +: CNT_W] <= lim_all[g*CNT_W +: CNT_W]);
      assert_settings_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_all[g*CNT_W +: CNT_W] != '0) |-> $stable(lim_all[g*CNT_W +: CNT_W]));
      assert_memory_nonzero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_codes[2*g +: 2] != 2'b00);
    end
  endgenerate
endmodule

bind freq_gen_bank fg_checker #(.NUM_GEN(NUM_GEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .gen_out(gen_out),
  .cnt_all(cnt_all), .lim_all(lim_all), .mem_codes(mem_codes)
);

// File: tb/freq_gen_bank_test.sv
module freq_gen_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 4000;

  logic        clk, rst_n;
  logic [2:0]  tick;
  logic        wen_e, wen_l;
  logic [1:0]  waddr, raddr;
  logic [31:0] wdata, rd_e, rd_l;
  logic [5:0]  out_e, out_l;
  int          n_chk = 0, n_bad = 0, cyc = 0;

  freq_gen_bank #(.LEGACY_LAYOUT(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wen_e), .wr_addr(waddr), .wr_data(wdata),
    .rd_addr(raddr), .rd_data(rd_e), .src_tick(tick), .gen_out(out_e));

  freq_gen_bank #(.LEGACY_LAYOUT(1'b1)) uut_leg (
    .clk(clk), .rst_n(rst_n), .wr_en(wen_l), .wr_addr(waddr), .wr_data(wdata),
    .rd_addr(raddr), .rd_data(rd_l), .src_tick(tick), .gen_out(out_l));

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  // source strobes: CPU every 2, aux1 every 3, aux2 every 5 cycles
  initial begin
    tick = '0;
    forever begin
      @(negedge clk);
      cyc++;
      tick[0] = (cyc % 2 == 0);
      tick[1] = (cyc % 3 == 0);
      tick[2] = (cyc % 5 == 0);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input bit leg, input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    waddr = a; wdata = d;
    if (leg) wen_l = 1'b1; else wen_e = 1'b1;
    @(negedge clk);
    wen_e = 1'b0; wen_l = 1'b0;
  endtask

  task automatic rd(input bit leg, input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    raddr = a;
    #1;
    d = leg ? rd_l : rd_e;
  endtask

  function automatic bit ob(input bit leg, input int g);
    return leg ? out_l[g] : out_e[g];
  endfunction

  task automatic measure(input bit leg, input int g, output int per, output int hi, output bit ok);
    int t;
    ok = 1; per = 0; hi = 0; t = 0;
    while (ob(leg, g) && t < TMO) begin @(negedge clk); t++; end
    while (!ob(leg, g) && t < TMO) begin @(negedge clk); t++; end
    while (ob(leg, g) && t < TMO) begin @(negedge clk); t++; hi++; end
    per = hi;
    while (!ob(leg, g) && t < TMO) begin @(negedge clk); t++; per++; end
    if (t >= TMO) ok = 0;
  endtask

  task automatic wave(input bit leg, input int g, input int eper, input int ehi, input string req);
    int p, h; bit ok;
    measure(leg, g, p, h, ok);
    measure(leg, g, p, h, ok);
    check(ok, {req, " timeout"}, 0, 1);
    check(p == eper, {req, " period"}, p, eper);
    check(h == ehi, {req, " high"}, h, ehi);
  endtask

  localparam logic [31:0] R0_EXT = (32'd1 << 30) | 32'd14 | (32'd9 << 10) | (32'd19 << 20);

  task automatic t_reset;
    logic [31:0] d;
    check(out_e == 0 && out_l == 0, "R12 outputs after reset", {out_l, out_e}, 0);
    rd(0, 0, d); check(d == 0, "R12 ctrl0 reset", d, 0);
    rd(0, 1, d); check(d == 0, "R12 ctrl1 reset", d, 0);
    rd(0, 2, d); check(d == 0, "R9 status reset", d, 0);
    rd(0, 3, d); check(d == 32'h555, "R12 remembered codes default 1", d, 32'h555);
    rd(1, 0, d); check(d == 0, "R12 legacy ctrl0 reset", d, 0);
  endtask

  task automatic t_ext_config;
    logic [31:0] d;
    wr(0, 0, R0_EXT & ~(32'd1 << 30));
    wave(0, 0, 16, 8, "R4 scale clear cpu D8");
    wr(0, 0, R0_EXT);
    rd(0, 0, d); check(d == R0_EXT, "R1 ctrl0 readback", d, R0_EXT);
    wave(0, 0, 8, 4, "R4 scale set cpu D4");
    wave(0, 1, 15, 5, "R3 code1 aux2 D3 R5 odd duty");
    wave(0, 2, 15, 6, "R3 code3 aux1 D5");
    wr(0, 1, 32'd14 | (32'd2 << 10));
    wave(0, 3, 16, 8, "R1 gen3 in reg1");
    wave(0, 4, 4, 2, "R5 even duty D2");
    wr(0, 1, (32'd1 << 30) | 32'd14 | (32'd2 << 10));
    wave(0, 4, 2, 1, "R6 divisor one follows strobe");
    wave(0, 3, 8, 4, "R4 reg1 scale set");
    rd(0, 2, d); check(d == 32'h1F, "R9 status ext", d, 32'h1F);
    rd(0, 3, d); check(d == 32'h6B6, "R12 direct write updates memory", d, 32'h6B6);
  endtask

  task automatic t_boundary;
    int c, t; logic [31:0] nv;
    nv = (R0_EXT & ~(32'h3FF << 20)) | (32'd7 << 20);
    t = 0;
    while (out_e[2] && t < TMO) begin @(negedge clk); t++; end
    while (!out_e[2] && t < TMO) begin @(negedge clk); t++; end
    waddr = 0; wdata = nv; wen_e = 1'b1;
    c = 0;
    @(negedge clk); c++; wen_e = 1'b0;
    while (out_e[2] && c < TMO) begin @(negedge clk); c++; end
    while (!out_e[2] && c < TMO) begin @(negedge clk); c++; end
    check(c == 9, "R7 change waits for period end", c, 9);
    wave(0, 2, 6, 3, "R7 new divider after boundary");
  endtask

  task automatic t_disable_preset;
    logic [31:0] d; int hi;
    wr(0, 2, 32'd1 << 8);
    hi = 0;
    for (int k = 0; k < 40; k++) begin @(negedge clk); if (out_e[0]) hi++; end
    check(hi == 0, "R8 disabled output low", hi, 0);
    rd(0, 0, d); check(d[1:0] == 0, "R10 disable writes code 0", d[1:0], 0);
    rd(0, 2, d); check(d == 32'h1E, "R9 status after disable", d, 32'h1E);
    wr(0, 3, 32'd3 | (32'd1 << 16));
    rd(0, 0, d); check(d[1:0] == 0, "R11 preset keeps off generator off", d[1:0], 0);
    rd(0, 3, d); check(d[1:0] == 3, "R11 preset stored", d[1:0], 3);
    wr(0, 2, 32'd1);
    rd(0, 0, d); check(d[1:0] == 3, "R10 enable restores remembered", d[1:0], 3);
    wave(0, 0, 12, 6, "R8 R11 restart on aux1");
    wr(0, 3, 32'd1 | (32'd1 << 16));
    rd(0, 0, d); check(d[1:0] == 1, "R11 preset applied when enabled", d[1:0], 1);
    wave(0, 0, 20, 10, "R11 aux2 after preset");
    wr(0, 3, 32'd0 | (32'd1 << 16));
    rd(0, 3, d); check(d[1:0] == 1, "R11 zero code ignored", d[1:0], 1);
    wr(0, 2, 32'd1 | (32'd1 << 8));
    rd(0, 0, d); check(d[1:0] == 0, "R10 disable wins", d[1:0], 0);
  endtask

  task automatic t_legacy;
    logic [31:0] d, v;
    v = (32'd1 << 30) | 32'd14 | (32'd7 << 10);
    wr(1, 0, v);
    rd(1, 0, d); check(d == v, "R1 legacy readback", d, v);
    wave(1, 0, 16, 8, "R2 legacy cpu scale ignored");
    wave(1, 1, 12, 6, "R2 legacy aux1 D4");
    wr(1, 3, 32'h003F_0FFF);
    wr(1, 2, 32'h0000_3F00);
    rd(1, 2, d); check(d == 32'h3, "R13 legacy commands ignored", d, 32'h3);
    rd(1, 3, d); check(d == 0, "R13 legacy addr3 reads 0", d, 0);
    rd(1, 0, d); check(d == v, "R13 legacy ctrl unchanged", d, v);
    wave(1, 0, 16, 8, "R13 legacy still running");
  endtask

  initial begin
    rst_n = 1'b0; wen_e = 1'b0; wen_l = 1'b0;
    waddr = '0; raddr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ext_config();
    t_boundary();
    t_disable_preset();
    t_legacy();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule